// File: doc/BRIEF.md
# Double-Buffered Compare PWM Generator

This block is a 16-bit up-counter with two output compare channels. It produces plain free-running counts, clear-on-match periods and single-slope (fast) PWM waveforms on two output pins. A mode code selects where the count period ends (TOP). That limit can be a fixed 8-, 9- or 10-bit value, the full 16-bit range, a capture-register value supplied from outside, or the active value of compare channel A.

In the PWM modes, compare writes land in a shadow register. The shadow is copied into the active compare register only on the timer clock where the counter wraps from TOP back to zero. A duty change therefore never produces a cut-short or stretched pulse. In the non-PWM modes, writes reach the active register at once.

A direct write to the counter suppresses compare matches on both channels for the next timer clock. Three sticky event flags are provided: overflow, match A and match B. Each flag is cleared by writing 1 to it, and each has its own interrupt enable into one interrupt line. Counting advances only on cycles where the timer clock enable is high.

Top module: `cmp_pwm_timer`

## Requirements
- R1: After reset the counter, both pins, all flags and irq are 0, and both the active and the shadow compare registers hold 0.
- R2: Mode code 0, and any code not listed in R3 to R5, counts 0 up to 0xFFFF and wraps to 0. The overflow flag (flags bit 0) sets on the tick where the count goes from 0xFFFF to 0.
- R3: Mode code 4 uses the active compare A value as TOP, and mode code 12 uses cap_val as TOP. On the tick at TOP the counter returns to 0. In these modes the overflow flag sets only when the count passes 0xFFFF.
- R4: Mode codes 5, 6 and 7 are fast PWM with TOP of 0x00FF, 0x01FF and 0x03FF. The counter returns to 0 on the tick at TOP, and the overflow flag sets on that wrap tick.
- R5: Mode code 14 is fast PWM with TOP equal to cap_val, and mode code 15 is fast PWM with TOP equal to the active compare A value. A TOP as small as 0x0003 gives a four-tick period.
- R6: Output mode 2 (non-inverted) in a PWM mode drives the pin to 0 on a match and to 1 on the wrap tick. When both happen on the same tick, the wrap wins.
- R7: Output mode 3 (inverted) in a PWM mode drives the pin to 1 on a match and to 0 on the wrap tick. When both happen on the same tick, the wrap wins.
- R8: In a PWM mode a compare write goes only to the shadow register. The active register takes the shadow value on the wrap tick and holds steady on every other cycle.
- R9: In a non-PWM mode a compare write reaches the active register at the next clock edge. On a match, output mode 2 drives the pin to 0 and output mode 3 drives it to 1.
- R10: A match is a tick with no counter write, not blocked, and count equal to the active compare value. A cnt_we cycle loads cnt_wdata in place of any tick, and the next tick produces no match on either channel.
- R11: flags bit 1 is match A and bit 2 is match B. A flag sets on its event and clears when written with 1 on flag_clr; a set wins over a clear in the same cycle. irq is the OR of flags AND irq_en.
- R12: Output mode 0 holds the pin at 0. Output mode 1 toggles the internal waveform on each match in every mode.
- R13: With tick low and no counter write, the counter, the pins and the set side of the flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable |
| mode | input | 4 | Waveform mode code |
| out_mode_a | input | 2 | Output mode, channel A |
| out_mode_b | input | 2 | Output mode, channel B |
| cmp_a_we | input | 1 | Compare A write strobe |
| cmp_a_wdata | input | 16 | Compare A write value |
| cmp_b_we | input | 1 | Compare B write strobe |
| cmp_b_wdata | input | 16 | Compare B write value |
| cap_val | input | 16 | Capture register value usable as TOP |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 16 | Counter write value |
| flag_clr | input | 3 | Write-1-to-clear for flags |
| irq_en | input | 3 | Per-flag interrupt enables |
| cnt | output | 16 | Current count |
| wave_a | output | 1 | Waveform pin A |
| wave_b | output | 1 | Waveform pin B |
| flags | output | 3 | Event flags {B match, A match, overflow} |
| irq | output | 1 | Interrupt request |

## Verification
The main function is driven through each TOP source: a full 16-bit wrap, clear-on-match from compare A and from the capture value, and the three fixed PWM widths. These runs separate the TOP multiplexing from the wrap and overflow logic. Fast PWM with TOP at the minimum of 3 and TOP from compare A, plus a duty change written in mid-period, shows whether the shadow copy happens only at the wrap. A counter write landing on a compare value, together with stretches of irregular tick patterns, separates the match blocking from plain idle cycles.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
  parameter int CPT_CW = 16;
  parameter int CPT_NCH = 2;
  typedef logic [CPT_CW-1:0] cnt_t;

  localparam logic [3:0] MD_NORMAL   = 4'd0;
  localparam logic [3:0] MD_CTC_A    = 4'd4;
  localparam logic [3:0] MD_FAST8    = 4'd5;
  localparam logic [3:0] MD_FAST9    = 4'd6;
  localparam logic [3:0] MD_FAST10   = 4'd7;
  localparam logic [3:0] MD_CTC_CAP  = 4'd12;
  localparam logic [3:0] MD_FAST_CAP = 4'd14;
  localparam logic [3:0] MD_FAST_A   = 4'd15;

  // fixed all-ones limit of a given bit width
  function automatic cnt_t ones_limit(input int bits);
    return cnt_t'((64'd1 << bits) - 64'd1);
  endfunction

  function automatic logic mode_is_pwm(input logic [3:0] m);
    return (m == MD_FAST8) || (m == MD_FAST9) || (m == MD_FAST10) ||
           (m == MD_FAST_CAP) || (m == MD_FAST_A);
  endfunction

  function automatic cnt_t mode_top(input logic [3:0] m, input cnt_t cmp_a, input cnt_t cap);
    case (m)
      MD_CTC_A, MD_FAST_A:    return cmp_a;
      MD_CTC_CAP, MD_FAST_CAP: return cap;
      MD_FAST8:  return ones_limit(8);
      MD_FAST9:  return ones_limit(9);
      MD_FAST10: return ones_limit(10);
      default:   return '1;
    endcase
  endfunction

  // next internal waveform level of one channel
  function automatic logic wave_next(input logic [1:0] om, input logic pwm,
                                     input logic hit, input logic wrap, input logic cur);
    case (om)
      2'd1: return hit ? ~cur : cur;
      2'd2: return (pwm && wrap) ? 1'b1 : (hit ? 1'b0 : cur);
      2'd3: return (pwm && wrap) ? 1'b0 : (hit ? 1'b1 : cur);
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/cpt_counter.sv
module cpt_counter
  import cpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [3:0] mode,
  input  cnt_t       cmp_a_act,
  input  cnt_t       cap_val,
  input  logic       cnt_we,
  input  cnt_t       cnt_wdata,
  output cnt_t       cnt,
  output logic       run_tick,
  output logic       wrap_evt,
  output logic       ovf_evt,
  output logic       blocked
);
  cnt_t top_w;

  always_comb begin
    top_w    = mode_top(mode, cmp_a_act, cap_val);
    run_tick = tick & ~cnt_we;
    wrap_evt = run_tick & (cnt == top_w);
    ovf_evt  = mode_is_pwm(mode) ? wrap_evt : (run_tick & (cnt == '1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      blocked <= 1'b0;
    end else if (cnt_we) begin
      cnt     <= cnt_wdata;
      blocked <= 1'b1;
    end else if (run_tick) begin
      cnt     <= wrap_evt ? '0 : cnt + cnt_t'(1);
      blocked <= 1'b0;
    end
  end
endmodule

// File: rtl/cpt_channel.sv
module cpt_channel
  import cpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm,
  input  logic       run_tick,
  input  logic       blocked,
  input  logic       wrap_evt,
  input  cnt_t       cnt,
  input  logic       we,
  input  cnt_t       wdata,
  input  logic [1:0] out_mode,
  output cnt_t       active,
  output logic       hit,
  output logic       pin
);
  cnt_t shadow;
  logic wv;

  assign hit = run_tick & ~blocked & (cnt == active);
  assign pin = (out_mode != 2'd0) & wv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      active <= '0;
      wv     <= 1'b0;
    end else begin
      if (we) shadow <= wdata;
      if (!pwm && we)          active <= wdata;
      else if (pwm && wrap_evt) active <= shadow;
      wv <= wave_next(out_mode, pwm, hit, wrap_evt, wv);
    end
  end
endmodule

// File: rtl/cpt_flags.sv
module cpt_flags #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] evt,
  input  logic [NF-1:0] clr,
  input  logic [NF-1:0] en,
  output logic [NF-1:0] flags,
  output logic          irq
);
  assign irq = |(flags & en);

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | evt;
  end
endmodule

// File: rtl/cmp_pwm_timer.sv
module cmp_pwm_timer
  import cpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [3:0]        mode,
  input  logic [1:0]        out_mode_a,
  input  logic [1:0]        out_mode_b,
  input  logic              cmp_a_we,
  input  logic [CPT_CW-1:0] cmp_a_wdata,
  input  logic              cmp_b_we,
  input  logic [CPT_CW-1:0] cmp_b_wdata,
  input  logic [CPT_CW-1:0] cap_val,
  input  logic              cnt_we,
  input  logic [CPT_CW-1:0] cnt_wdata,
  input  logic [CPT_NCH:0]  flag_clr,
  input  logic [CPT_NCH:0]  irq_en,
  output logic [CPT_CW-1:0] cnt,
  output logic              wave_a,
  output logic              wave_b,
  output logic [CPT_NCH:0]  flags,
  output logic              irq
);
  localparam int NF = CPT_NCH + 1;

  logic       run_tick, wrap_evt, ovf_evt, blocked, pwm_on;
  cnt_t       ocr_v   [CPT_NCH];
  cnt_t       wd_v    [CPT_NCH];
  logic [1:0] om_v    [CPT_NCH];
  logic       we_v    [CPT_NCH];
  logic       hit_v   [CPT_NCH];
  logic       pin_v   [CPT_NCH];
  logic [NF-1:0] evt_v;

  assign pwm_on  = mode_is_pwm(mode);
  assign wd_v[0] = cmp_a_wdata;
  assign wd_v[1] = cmp_b_wdata;
  assign om_v[0] = out_mode_a;
  assign om_v[1] = out_mode_b;
  assign we_v[0] = cmp_a_we;
  assign we_v[1] = cmp_b_we;
  assign wave_a  = pin_v[0];
  assign wave_b  = pin_v[1];

  cpt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
    .cmp_a_act(ocr_v[0]), .cap_val(cap_val),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt(cnt),
    .run_tick(run_tick), .wrap_evt(wrap_evt), .ovf_evt(ovf_evt), .blocked(blocked)
  );

  assign evt_v[0] = ovf_evt;

  for (genvar g = 0; g < CPT_NCH; g++) begin : g_ch
    cpt_channel u_ch (
      .clk(clk), .rst_n(rst_n), .pwm(pwm_on), .run_tick(run_tick),
      .blocked(blocked), .wrap_evt(wrap_evt), .cnt(cnt),
      .we(we_v[g]), .wdata(wd_v[g]), .out_mode(om_v[g]),
      .active(ocr_v[g]), .hit(hit_v[g]), .pin(pin_v[g])
    );
    assign evt_v[g+1] = hit_v[g];
  end

  cpt_flags #(.NF(NF)) u_flg (
    .clk(clk), .rst_n(rst_n), .evt(evt_v), .clr(flag_clr), .en(irq_en),
    .flags(flags), .irq(irq)
  );
endmodule

// File: rtl/cpt_checker.sv
module cpt_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         cnt_we,
  input logic         pwm_on,
  input logic         wrap_evt,
  input logic         hit_a,
  input logic         hit_b,
  input logic         cmp_a_we,
  input logic [W-1:0] cmp_a_wdata,
  input logic [W-1:0] ocr_a,
  input logic [1:0]   out_mode_a,
  input logic         wave_a,
  input logic [W-1:0] cnt,
  input logic [2:0]   flags
);
  a_r13_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_we) |=> $stable(cnt));

  a_r10_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (!hit_a && !hit_b));

  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cnt == '0));

  a_r11_flag_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit_b |=> flags[2]);

  a_r9_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_on && cmp_a_we) |=> (ocr_a == $past(cmp_a_wdata)));

  a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_on && !wrap_evt) |=> $stable(ocr_a));

  a_r6_set_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_on && wrap_evt && out_mode_a == 2'd2) |=> (wave_a || out_mode_a == 2'd0));
endmodule

bind cmp_pwm_timer cpt_checker #(.W(cpt_pkg::CPT_CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_we(cnt_we), .pwm_on(pwm_on),
  .wrap_evt(wrap_evt), .hit_a(hit_v[0]), .hit_b(hit_v[1]),
  .cmp_a_we(cmp_a_we), .cmp_a_wdata(cmp_a_wdata), .ocr_a(ocr_v[0]),
  .out_mode_a(out_mode_a), .wave_a(wave_a), .cnt(cnt), .flags(flags)
);

// File: tb/cmp_pwm_timer_tb.sv
`timescale 1ns/1ps
module cmp_pwm_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        d_tick = 0, d_awe = 0, d_bwe = 0, d_cwe = 0;
  logic [3:0]  d_mode = 0;
  logic [1:0]  d_oma = 0, d_omb = 0;
  logic [15:0] d_awd = 0, d_bwd = 0, d_cap = 0, d_cwd = 0;
  logic [2:0]  d_clr = 0, d_en = 0;

  logic [15:0] cnt_o;
  logic        wa_o, wb_o, irq_o;
  logic [2:0]  fl_o;

  cmp_pwm_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick(d_tick), .mode(d_mode),
    .out_mode_a(d_oma), .out_mode_b(d_omb),
    .cmp_a_we(d_awe), .cmp_a_wdata(d_awd), .cmp_b_we(d_bwe), .cmp_b_wdata(d_bwd),
    .cap_val(d_cap), .cnt_we(d_cwe), .cnt_wdata(d_cwd),
    .flag_clr(d_clr), .irq_en(d_en),
    .cnt(cnt_o), .wave_a(wa_o), .wave_b(wb_o), .flags(fl_o), .irq(irq_o)
  );

  int total = 0, bad = 0;
  string cur = "R1";
  bit rnd_tick = 0;

  // reference state, expected after the most recent edge
  int m_cnt = 0, m_blk = 0, m_fl = 0;
  int m_act[2], m_sh[2], m_w[2];

  function automatic int limit_of(int md);
    if (md == 4 || md == 15) return m_act[0];
    if (md == 12 || md == 14) return int'(d_cap);
    if (md == 5) return 255;
    if (md == 6) return 511;
    if (md == 7) return 1023;
    return 65535;
  endfunction

  task automatic ref_step();
    int lim, om, wd;
    bit fast, go, wr, ov, we;
    bit h[2];
    fast = (d_mode >= 5 && d_mode <= 7) || d_mode == 14 || d_mode == 15;
    lim  = limit_of(int'(d_mode));
    go   = d_tick && !d_cwe;
    wr   = go && (m_cnt == lim);
    ov   = fast ? wr : (go && m_cnt == 65535);
    for (int i = 0; i < 2; i++) h[i] = go && (m_blk == 0) && (m_cnt == m_act[i]);
    for (int i = 0; i < 2; i++) begin
      om = (i == 0) ? int'(d_oma) : int'(d_omb);
      we = (i == 0) ? d_awe : d_bwe;
      wd = (i == 0) ? int'(d_awd) : int'(d_bwd);
      if (om == 1 && h[i]) m_w[i] = 1 - m_w[i];
      if (om == 2) begin
        if (fast && wr) m_w[i] = 1; else if (h[i]) m_w[i] = 0;
      end
      if (om == 3) begin
        if (fast && wr) m_w[i] = 0; else if (h[i]) m_w[i] = 1;
      end
      if (fast) begin
        if (wr) m_act[i] = m_sh[i];
      end else if (we) m_act[i] = wd;
      if (we) m_sh[i] = wd;
    end
    m_fl = (m_fl & ~int'(d_clr)) | (ov ? 1 : 0) | (h[0] ? 2 : 0) | (h[1] ? 4 : 0);
    if (d_cwe) begin
      m_cnt = int'(d_cwd); m_blk = 1;
    end else if (go) begin
      m_cnt = wr ? 0 : (m_cnt + 1) % 65536; m_blk = 0;
    end
  endtask

  task automatic check1(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int pa, pb;
    pa = (d_oma != 0) ? m_w[0] : 0;
    pb = (d_omb != 0) ? m_w[1] : 0;
    check1("cnt", int'(cnt_o), m_cnt);
    check1("wave_a", int'(wa_o), pa);
    check1("wave_b", int'(wb_o), pb);
    check1("flags", int'(fl_o), m_fl);
    check1("irq", int'(irq_o), ((m_fl & int'(d_en)) != 0) ? 1 : 0);
  endtask

  // one clock: model advances with the current inputs, outputs compared at the falling edge
  task automatic step();
    if (rnd_tick) d_tick = ($urandom % 4) != 0;
    ref_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    d_awe = 0; d_bwe = 0; d_cwe = 0; d_clr = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr_cnt(int v);
    d_cwe = 1; d_cwd = 16'(v); step();
  endtask

  task automatic wr_cmp(int a, int b);
    if (a >= 0) begin d_awe = 1; d_awd = 16'(a); end
    if (b >= 0) begin d_bwe = 1; d_bwd = 16'(b); end
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog: cycles=150000 expected=end of test");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin m_act[i] = 0; m_sh[i] = 0; m_w[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    cur = "R1"; compare_all();

    cur = "R13"; d_tick = 0; d_mode = 0; run(5);

    cur = "R2"; d_en = 3'b111; wr_cnt(16'hFFF0);
    d_tick = 1; run(40);
    d_mode = 4'd9; wr_cnt(16'hFFFE); run(6);
    d_mode = 0;

    cur = "R11"; d_clr = 3'b111; step(); run(3);
    d_en = 3'b010; run(2);

    cur = "R12"; d_oma = 1; d_omb = 0; wr_cmp(5, 9); wr_cnt(0);
    rnd_tick = 1; run(40); rnd_tick = 0; d_tick = 1;

    cur = "R9"; d_omb = 3; d_oma = 2; wr_cmp(20, 12); wr_cnt(0); run(30);

    cur = "R10"; d_tick = 1; wr_cnt(20); run(3); wr_cnt(12); run(3);

    cur = "R3"; d_mode = 4; d_oma = 1; d_omb = 3; wr_cmp(20, 7); wr_cnt(0); run(70);
    d_mode = 12; d_cap = 13; wr_cnt(0); run(50);

    cur = "R6"; d_mode = 5; d_oma = 2; d_omb = 3; d_clr = 3'b111;
    wr_cmp(100, 200); wr_cnt(0); run(300);
    cur = "R7"; run(300);

    cur = "R8"; wr_cmp(50, 30); run(150); wr_cmp(255, -1); run(300);

    cur = "R4"; d_mode = 6; wr_cnt(16'h01F0); run(40);
    d_mode = 7; wr_cnt(16'h03F0); run(40);

    cur = "R5"; d_mode = 14; d_cap = 3; wr_cmp(50, 1); wr_cnt(0); run(30);
    d_mode = 15; wr_cmp(9, 4); run(120);

    cur = "R13"; d_mode = 5; wr_cmp(60, 180); rnd_tick = 1; run(800); rnd_tick = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule